// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns the demodulated, active-low output of an infrared receiver into data words. It handles pulse-distance frames of the NEC kind. The input passes through a two-flop synchronizer and a glitch filter with a programmable length. A prescaler then produces a base tick, and every measured interval is counted in ticks and matched against a fixed min/max window. A frame starts with a long mark and a space. A data leader space is followed by a programmable number of bits. Each bit is a fall-to-fall period that is either short (0) or long (1). A short leader space instead marks a repeat frame, which carries no data.

Software drives the block through three word registers: control at address 0, status at address 1 and the frame word at address 2. Reading status clears the event flags and drops the interrupt. An optional hold mode keeps a captured word until it is read. An interval that fits no window, or a frame that runs too long, silently returns the decoder to waiting for a leader.

Top module: `irpd_decoder`

## Requirements
- R1: After reset, control reads 0x001373F0: run=0 (bit 0), clr=0 (bit 1), msb=0 (bit 2), hold=0 (bit 3), one-enable=1 (bit 4), length N-1=31 (bits 9:5), filter=7 (bits 14:12), tick divider=19 (bits 27:16). Status, frame and irq all read 0. One tick lasts (divider+1)·CYC_PER_US clocks.
- R2: The leader mark must last 400..500 ticks and the data leader space 200..300 ticks. Any other leader aborts the frame without setting a flag or changing the frame word.
- R3: A fall-to-fall bit period of 40..72 ticks decodes as 0 and one of 90..134 ticks decodes as 1. After N bits, status bit 3 (valid) is set and irq rises.
- R4: A leader space of 80..150 ticks sets status bit 0 (repeat) and irq, leaves valid clear and leaves the frame word unchanged.
- R5: By default, the k-th received bit lands in word bit k. With control bit 2 set, bits shift in from the LSB side, so the first bit ends up most significant.
- R6: On each completed frame, status bit 1 is set if word[15:8] != ~word[7:0], and status bit 2 is set if word[31:24] != ~word[23:16].
- R7: When control bit 4 is clear, a long (1) period aborts the frame. Frames made only of 0 bits still decode.
- R8: A read of status (address 1) clears status bits 3..0, and irq then goes low. irq equals valid OR repeat.
- R9: With control bit 3 set, a captured word is not overwritten until address 2 is read. Status bit 5 shows that a word is being held.
- R10: The input level is accepted only after it has stayed stable for filter+1 clocks. With a filter of 7, a 3-clock glitch inside the leader mark has no effect. With a filter of 0, the same glitch breaks the leader.
- R11: Control bit 0 enables decoding. Control bit 1 holds the decoder idle and clears status and frame. Status bit 4 (busy) is high while a frame is in progress.
- R12: Control bits 9:5 set the frame length as N-1. A length of 7 captures 8 bits into word bits 7:0.
- R13: A frame still in progress more than 4000 ticks after its leader started is aborted, and valid is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_rx_n | input | 1 | Demodulated receiver output, low during a mark |
| reg_addr | input | 2 | Register address: 0 control, 1 status, 2 frame |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe (control register only) |
| reg_re | input | 1 | Read strobe; triggers the clear-on-read side effects |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | 1 | Interrupt: valid or repeat pending |

## Verification
The bench goes after the interval classification edges. A leader mark that is too short must leave the frame word and flags untouched. A decoder that ignored the window would latch garbage. A repeat leader must set only the repeat flag; a design that shared the capture path would overwrite the stored code. The bench also covers the bit-order and length variants. A wrong shift direction shows up as a bit-reversed word, and a miscounted length shows up as a misplaced byte. It checks hold mode, where a design that overwrites early returns the second frame. The glitch filter is tested at settings 7 and 0. The whole-frame timeout uses an all-ones frame whose individual bits are legal, and a missing timeout would report it valid.

// File: rtl/irpd_pkg.sv
package irpd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_LMARK  = 2'd1,
        PH_LSPACE = 2'd2,
        PH_BITS   = 2'd3
    } phase_e;

    localparam logic [1:0] ADR_CTRL  = 2'd0;
    localparam logic [1:0] ADR_STAT  = 2'd1;
    localparam logic [1:0] ADR_FRAME = 2'd2;

    localparam int SB_RPT   = 0;
    localparam int SB_CERR  = 1;
    localparam int SB_DERR  = 2;
    localparam int SB_VALID = 3;
    localparam int SB_BUSY  = 4;
    localparam int SB_HELD  = 5;

endpackage

// File: rtl/irpd_filter.sv
module irpd_filter #(
    parameter int FLT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_n,
    input  logic [FLT_W-1:0] setting,
    output logic             lvl
);
    typedef struct packed {
        logic             s1;
        logic             s2;
        logic             lvl;
        logic [FLT_W-1:0] run;
    } flt_s;

    flt_s q, d;

    always_comb begin
        d    = q;
        d.s1 = raw_n;
        d.s2 = q.s1;
        if (q.s2 == q.lvl) begin
            d.run = '0;
        end else if (q.run == setting) begin
            d.lvl = q.s2;
            d.run = '0;
        end else begin
            d.run = q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, lvl: 1'b1, run: '0};
        else        q <= d;
    end

    assign lvl = q.lvl;

    // R10: the output only moves after the synchronized input disagreed with it
    p_lvl_follows_input_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.lvl) |-> $past(q.s2 != q.lvl));

endmodule

// File: rtl/irpd_tick.sv
module irpd_tick #(
    parameter int CYC_PER_US = 125,
    parameter int DIV_W      = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int US_W = $clog2(CYC_PER_US + 1);
    localparam logic [US_W-1:0] US_LAST = US_W'(CYC_PER_US - 1);

    typedef struct packed {
        logic [US_W-1:0]  us;
        logic [DIV_W-1:0] dv;
        logic             tick;
    } tck_s;

    tck_s q, d;

    always_comb begin
        d      = q;
        d.tick = 1'b0;
        if (!run) begin
            d.us = '0;
            d.dv = '0;
        end else if (q.us == US_LAST) begin
            d.us = '0;
            if (q.dv >= div) begin
                d.dv   = '0;
                d.tick = 1'b1;
            end else begin
                d.dv = q.dv + 1'b1;
            end
        end else begin
            d.us = q.us + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick = q.tick;

    // R1: with a divider above zero, ticks never land on consecutive clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && div != '0 && $stable(div) && q.tick) |=> !q.tick);

endmodule

// File: rtl/irpd_core.sv
module irpd_core
    import irpd_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 13,
    parameter int LM_MIN    = 400,
    parameter int LM_MAX    = 500,
    parameter int LS_MIN    = 200,
    parameter int LS_MAX    = 300,
    parameter int RP_MIN    = 80,
    parameter int RP_MAX    = 150,
    parameter int B0_MIN    = 40,
    parameter int B0_MAX    = 72,
    parameter int B1_MIN    = 90,
    parameter int B1_MAX    = 134,
    parameter int FRAME_MAX = 4000,
    localparam int LEN_W    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              lvl,
    input  logic              msb_first,
    input  logic              one_en,
    input  logic [LEN_W-1:0]  len_m1,
    output logic              done,
    output logic              rpt,
    output logic [DATA_W-1:0] word,
    output logic              busy
);
    typedef struct packed {
        phase_e            phase;
        logic              prev;
        logic [CNT_W-1:0]  ivl;
        logic [CNT_W-1:0]  ftm;
        logic [LEN_W-1:0]  nbit;
        logic [DATA_W-1:0] sh;
        logic              done;
        logic              rpt;
    } core_s;

    core_s q, d;

    function automatic logic inwin(input logic [CNT_W-1:0] v, input int lo, input int hi);
        return (int'(v) >= lo) && (int'(v) <= hi);
    endfunction

    logic             fall, rise, bit_val, bit_ok;
    logic [CNT_W-1:0] ivl_inc, ftm_inc;

    always_comb begin
        fall    = q.prev & ~lvl;
        rise    = ~q.prev & lvl;
        ivl_inc = (tick && q.ivl != '1) ? q.ivl + 1'b1 : q.ivl;
        ftm_inc = (tick && q.ftm != '1) ? q.ftm + 1'b1 : q.ftm;
        bit_val = inwin(q.ivl, B1_MIN, B1_MAX);
        bit_ok  = inwin(q.ivl, B0_MIN, B0_MAX) || (one_en && bit_val);

        d      = q;
        d.prev = lvl;
        d.done = 1'b0;
        d.rpt  = 1'b0;
        d.ivl  = ivl_inc;
        d.ftm  = ftm_inc;

        if (!run) begin
            d.phase = PH_IDLE;
            d.ivl   = '0;
            d.ftm   = '0;
            d.nbit  = '0;
        end else begin
            unique case (q.phase)
                PH_IDLE: begin
                    d.ftm = '0;
                    d.ivl = '0;
                    if (fall) begin
                        d.phase = PH_LMARK;
                        d.sh    = '0;
                        d.nbit  = '0;
                    end
                end
                PH_LMARK: begin
                    if (rise) begin
                        d.ivl   = '0;
                        d.phase = inwin(q.ivl, LM_MIN, LM_MAX) ? PH_LSPACE : PH_IDLE;
                    end else if (int'(ivl_inc) > LM_MAX) begin
                        d.phase = PH_IDLE;
                    end
                end
                PH_LSPACE: begin
                    if (fall) begin
                        d.ivl = '0;
                        if (inwin(q.ivl, LS_MIN, LS_MAX)) begin
                            d.phase = PH_BITS;
                        end else begin
                            d.rpt   = inwin(q.ivl, RP_MIN, RP_MAX);
                            d.phase = PH_IDLE;
                        end
                    end else if (int'(ivl_inc) > LS_MAX) begin
                        d.phase = PH_IDLE;
                    end
                end
                PH_BITS: begin
                    if (fall) begin
                        d.ivl = '0;
                        if (!bit_ok) begin
                            d.phase = PH_IDLE;
                        end else begin
                            if (msb_first) d.sh = {q.sh[DATA_W-2:0], bit_val};
                            else           d.sh[q.nbit] = bit_val;
                            if (q.nbit == len_m1) begin
                                d.done  = 1'b1;
                                d.phase = PH_IDLE;
                            end else begin
                                d.nbit = q.nbit + 1'b1;
                            end
                        end
                    end else if (int'(ivl_inc) > B1_MAX) begin
                        d.phase = PH_IDLE;
                    end
                end
                default: d.phase = PH_IDLE;
            endcase
            if (q.phase != PH_IDLE && int'(ftm_inc) > FRAME_MAX && !d.done && !d.rpt)
                d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign rpt  = q.rpt;
    assign word = q.sh;
    assign busy = (q.phase != PH_IDLE);

    // R3: a completed word only comes out of the bit phase
    p_done_from_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.phase == PH_BITS));
    // R4: a repeat pulse only comes out of the leader space
    p_rpt_from_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        q.rpt |-> $past(q.phase == PH_LSPACE));
    // R11: halting the decoder drops busy on the next clock
    p_halt_idles_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !busy);

endmodule

// File: rtl/irpd_decoder.sv
module irpd_decoder
    import irpd_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CYC_PER_US = 125,
    parameter int FLT_W      = 3,
    parameter int DIV_W      = 12,
    parameter int CNT_W      = 13,
    parameter int FRAME_MAX  = 4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ir_rx_n,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        reg_we,
    input  logic        reg_re,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int LEN_W = $clog2(DATA_W);

    typedef struct packed {
        logic              run;
        logic              clr;
        logic              msb;
        logic              hold;
        logic              one_en;
        logic [LEN_W-1:0]  len_m1;
        logic [FLT_W-1:0]  filt;
        logic [DIV_W-1:0]  div;
        logic              valid;
        logic              rptf;
        logic              cerr;
        logic              derr;
        logic              held;
        logic [DATA_W-1:0] frame;
    } regs_s;

    regs_s q, d;

    logic              lvl, tick, go;
    logic              core_done, core_rpt, core_busy;
    logic [DATA_W-1:0] core_word;

    assign go = q.run & ~q.clr;

    irpd_filter #(.FLT_W(FLT_W)) u_filter (
        .clk(clk), .rst_n(rst_n), .raw_n(ir_rx_n), .setting(q.filt), .lvl(lvl)
    );

    irpd_tick #(.CYC_PER_US(CYC_PER_US), .DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(go), .div(q.div), .tick(tick)
    );

    irpd_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .FRAME_MAX(FRAME_MAX)) u_core (
        .clk(clk), .rst_n(rst_n), .run(go), .tick(tick), .lvl(lvl),
        .msb_first(q.msb), .one_en(q.one_en), .len_m1(q.len_m1),
        .done(core_done), .rpt(core_rpt), .word(core_word), .busy(core_busy)
    );

    logic stat_rd, frame_rd;
    assign stat_rd  = reg_re && reg_addr == ADR_STAT;
    assign frame_rd = reg_re && reg_addr == ADR_FRAME;

    always_comb begin
        d = q;
        if (reg_we && reg_addr == ADR_CTRL) begin
            d.run    = reg_wdata[0];
            d.clr    = reg_wdata[1];
            d.msb    = reg_wdata[2];
            d.hold   = reg_wdata[3];
            d.one_en = reg_wdata[4];
            d.len_m1 = reg_wdata[5 +: LEN_W];
            d.filt   = reg_wdata[12 +: FLT_W];
            d.div    = reg_wdata[16 +: DIV_W];
        end
        if (stat_rd) begin
            d.valid = 1'b0;
            d.rptf  = 1'b0;
            d.cerr  = 1'b0;
            d.derr  = 1'b0;
        end
        if (frame_rd) d.held = 1'b0;
        if (core_done) begin
            d.valid = 1'b1;
            d.cerr  = core_word[15:8]  != ~core_word[7:0];
            d.derr  = core_word[31:24] != ~core_word[23:16];
            if (!(q.hold && d.held)) begin
                d.frame = core_word;
                d.held  = q.hold;
            end
        end
        if (core_rpt) d.rptf = 1'b1;
        if (q.clr) begin
            d.valid = 1'b0;
            d.rptf  = 1'b0;
            d.cerr  = 1'b0;
            d.derr  = 1'b0;
            d.held  = 1'b0;
            d.frame = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.one_en <= 1'b1;
            q.len_m1 <= LEN_W'(DATA_W - 1);
            q.filt   <= '1;
            q.div    <= DIV_W'(19);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[0]              = q.run;
                reg_rdata[1]              = q.clr;
                reg_rdata[2]              = q.msb;
                reg_rdata[3]              = q.hold;
                reg_rdata[4]              = q.one_en;
                reg_rdata[5 +: LEN_W]     = q.len_m1;
                reg_rdata[12 +: FLT_W]    = q.filt;
                reg_rdata[16 +: DIV_W]    = q.div;
            end
            ADR_STAT: begin
                reg_rdata[SB_RPT]   = q.rptf;
                reg_rdata[SB_CERR]  = q.cerr;
                reg_rdata[SB_DERR]  = q.derr;
                reg_rdata[SB_VALID] = q.valid;
                reg_rdata[SB_BUSY]  = core_busy;
                reg_rdata[SB_HELD]  = q.held;
            end
            ADR_FRAME: reg_rdata = q.frame;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = q.valid | q.rptf;

    // R8: a status read with no new event leaves the interrupt low
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !core_done && !core_rpt) |=> !irq);
    // R9: a held word survives until the frame register is read
    p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold && q.held && !frame_rd && !q.clr) |=> $stable(q.frame));
    // R3: valid rises only after the core reported a finished frame
    p_valid_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.valid) |-> $past(core_done));
    // R4: repeat flag rises only after a repeat leader
    p_rpt_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rptf) |-> $past(core_rpt));

endmodule

// File: tb/irpd_decoder_tb.sv
module irpd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_n = 1'b1;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] BASE = 32'h0000_73F1;
    localparam logic [31:0] WA   = 32'hC33C_A55A;
    localparam logic [31:0] WB   = 32'hFF00_FE01;

    always #4 clk = ~clk;

    irpd_decoder #(.CYC_PER_US(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_re(reg_re),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    task automatic mark(input int n);
        ir_n = 1'b0; clocks(n);
    endtask

    task automatic space(input int n);
        ir_n = 1'b1; clocks(n);
    endtask

    // bit i of w is sent i-th; glitch splits the leader mark with a 3-clock high
    task automatic send(input logic [31:0] w, input int n, input int lm, input int ls, input bit glitch);
        if (glitch) begin mark(200); space(3); mark(247); end
        else mark(lm);
        space(ls);
        for (int i = 0; i < n; i++) begin
            mark(28);
            space(w[i] ? 84 : 28);
        end
        mark(28);
        space(60);
    endtask

    // R8: irq must always agree with the valid and repeat bits of status
    always @(negedge clk) begin
        #2;
        if (rst_n && reg_addr == 2'd1) begin
            checks++;
            if (irq !== (reg_rdata[0] | reg_rdata[3])) begin
                errors++;
                $display("FAIL R8 irq actual=%b expected=%b", irq, reg_rdata[0] | reg_rdata[3]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] rev;
        clocks(3);
        rst_n = 1'b1;
        clocks(2);

        // R1 reset state
        chk({31'd0, irq}, 32'd0, "R1 irq");
        rd(2'd0, v); chk(v, 32'h0013_73F0, "R1 ctrl");
        rd(2'd1, v); chk(v, 32'd0, "R1 status");
        rd(2'd2, v); chk(v, 32'd0, "R1 frame");

        wr(2'd0, BASE);

        // R3/R5/R6/R8 basic frame
        send(WA, 32, 450, 225, 1'b0);
        chk({31'd0, irq}, 32'd1, "R3 irq after frame");
        rd(2'd2, v); chk(v, WA, "R5 lsb-first word");
        rd(2'd1, v); chk(v, 32'h08, "R6 status no errors");
        chk({31'd0, irq}, 32'd0, "R8 irq after status read");
        rd(2'd1, v); chk(v, 32'h00, "R8 status cleared");

        // R11 busy during a frame
        fork
            send(WB, 32, 450, 225, 1'b0);
            begin clocks(1000); rd(2'd1, v); chk(v, 32'h10, "R11 busy mid frame"); end
        join
        rd(2'd1, v); chk(v, 32'h08, "R3 second frame valid");
        rd(2'd2, v); chk(v, WB, "R3 second frame word");

        // R4 repeat frame
        mark(450); space(112); mark(28); space(60);
        chk({31'd0, irq}, 32'd1, "R4 irq on repeat");
        rd(2'd1, v); chk(v, 32'h01, "R4 repeat status");
        rd(2'd2, v); chk(v, WB, "R4 frame unchanged");

        // R6 error flags
        send(32'h00FF_005A, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h0A, "R6 custom error");
        send(32'h1201_A55A, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h0C, "R6 data error");

        // R2 leader windows
        send(WA, 32, 300, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h00, "R2 short mark aborts");
        send(WA, 32, 450, 170, 1'b0);
        rd(2'd1, v); chk(v, 32'h00, "R2 bad space aborts");
        rd(2'd2, v); chk(v, 32'h1201_A55A, "R2 frame untouched");

        // R5 msb-first
        wr(2'd0, BASE | 32'h4);
        send(WA, 32, 450, 225, 1'b0);
        for (int i = 0; i < 32; i++) rev[31-i] = WA[i];
        rd(2'd2, v); chk(v, rev, "R5 msb-first word");
        rd(2'd1, v); chk(v & 32'h08, 32'h08, "R5 msb-first valid");

        // R12 length of 8
        wr(2'd0, (BASE & ~32'h3E0) | 32'hE0);
        send(32'h0000_00A5, 8, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h0E, "R12 short frame status");
        rd(2'd2, v); chk(v, 32'h0000_00A5, "R12 short frame word");

        // R7 logic-1 matching off
        wr(2'd0, BASE & ~32'h10);
        send(WA, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h00, "R7 one period aborts");
        send(32'h0, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h0E, "R7 zeros still decode");
        rd(2'd2, v); chk(v, 32'h0, "R7 zero word");

        // R9 hold until read
        wr(2'd0, BASE | 32'h8);
        send(WA, 32, 450, 225, 1'b0);
        send(WB, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h28, "R9 valid and held");
        rd(2'd2, v); chk(v, WA, "R9 first word kept");
        send(WB, 32, 450, 225, 1'b0);
        rd(2'd2, v); chk(v, WB, "R9 new word after read");
        wr(2'd0, BASE);
        rd(2'd1, v);

        // R10 glitch filter
        send(WA, 32, 0, 225, 1'b1);
        rd(2'd1, v); chk(v, 32'h08, "R10 glitch filtered");
        rd(2'd2, v); chk(v, WA, "R10 glitch word");
        wr(2'd0, BASE & ~32'h7000);
        send(WB, 32, 0, 225, 1'b1);
        rd(2'd1, v); chk(v, 32'h00, "R10 unfiltered glitch breaks leader");
        wr(2'd0, BASE);

        // R13 whole-frame limit
        send(32'hFFFF_FFFF, 32, 450, 225, 1'b0);
        rd(2'd1, v); chk(v, 32'h00, "R13 long frame aborted");
        rd(2'd2, v); chk(v, WA, "R13 frame unchanged");

        // R11 clear mid frame
        fork
            send(WA, 32, 450, 225, 1'b0);
            begin
                clocks(1000);
                wr(2'd0, BASE | 32'h2);
                rd(2'd1, v); chk(v, 32'h00, "R11 clr drops busy");
                rd(2'd2, v); chk(v, 32'h0, "R11 clr clears frame");
                wr(2'd0, BASE);
            end
        join
        rd(2'd1, v); chk(v, 32'h00, "R11 aborted frame not valid");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule